// File: doc/BRIEF.md
# Backup Supply Switchover and Reset Supervisor

This block is the digital control for a battery-backed SRAM supply. Three comparator flags describe the main supply. One says it is above the trip level. One says it is below the switchover level. One says it is below the backup cell voltage. From these flags the block decides, once per clock, whether the SRAM rail should be fed from the backup cell. It also drives an active-low reset for the rest of the system.

A cell fitted at manufacture must not be drained on the shelf. For that reason the block starts in a sealed state in which the cell is never selected. The seal is broken only after the main supply has come up past the trip level once. After that, a later fall below both the switchover level and the cell voltage moves the rail onto the cell. An attachment event reported while the supply is down reseals the block.

The reset output drops at once whenever the supply is below trip. It is released only after the supply has stayed above trip for a programmable number of clock cycles. The same path serves as the power-on reset.

Top module: `bkup_switch_supervisor`

## Requirements
- R1: `bat_sel` is high in a cycle only if, at the preceding clock edge, both `vcc_below_switch` and `vcc_below_bat` were high; either flag alone never selects the cell.
- R2: After `rst_n` is released, `bat_sel` stays low for any flag pattern until `vcc_above_trip` has been sampled high at least once (sealed state).
- R3: Once `vcc_above_trip` has been sampled high, the first edge that samples both below-flags high sets `bat_sel` high one clock later, and it stays high while both stay high.
- R4: From backup, an edge that samples either below-flag low clears `bat_sel` one clock later, and the block stays unsealed.
- R5: An edge that samples `battery_attach_event` high with `vcc_above_trip` low reseals the block: `bat_sel` is low after that edge and stays low until `vcc_above_trip` is sampled high again.
- R6: An edge that samples `battery_attach_event` high while `vcc_above_trip` is high has no effect: a later fall below both levels still selects the cell.
- R7: `rst_out_n` is low in any cycle in which `vcc_above_trip` is low, with no clock delay.
- R8: `rst_out_n` goes high after exactly `HOLD_CYCLES` consecutive clock edges that sample `vcc_above_trip` high, and not earlier.
- R9: An edge that samples `vcc_above_trip` low during the hold period restarts the count, so a full `HOLD_CYCLES` further high edges are needed.
- R10: While `rst_n` is low, `bat_sel` and `rst_out_n` are both low; the block leaves reset in the sealed state with the hold count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| vcc_above_trip | input | 1 | Main supply is above the trip level |
| vcc_below_switch | input | 1 | Main supply is below the switchover level |
| vcc_below_bat | input | 1 | Main supply is below the backup cell voltage |
| battery_attach_event | input | 1 | One-cycle pulse reporting that a cell was attached |
| bat_sel | output | 1 | High selects the backup cell for the SRAM rail |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The bench builds the block with `HOLD_CYCLES` set to 8, in place of a default sized for about 200 ms. At that size, the exact release edge, a restart one edge before release, and the instant drop can all be checked cycle by cycle in a short run. The selection table walks the sealed state, arming, single-flag falls, entering and leaving backup, and both kinds of attachment event. Each entry is checked one clock after it is applied.

// File: rtl/bkup_switch_pkg.sv
package bkup_switch_pkg;

    // Source of the SRAM rail as seen by the selection logic
    typedef enum logic [1:0] {
        SRC_SEALED = 2'd0,   // cell fitted, never armed
        SRC_MAIN   = 2'd1,   // armed, rail on main supply
        SRC_BACKUP = 2'd2    // rail on backup cell
    } src_mode_e;

    typedef struct packed {
        src_mode_e mode;
    } sel_state_t;

endpackage

// File: rtl/supply_select_fsm.sv
module supply_select_fsm
    import bkup_switch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic above_trip,
    input  logic below_switch,
    input  logic below_bat,
    input  logic attach_evt,
    output logic bat_sel
);

    sel_state_t st_d, st_q;
    logic       fall_both;
    logic       reseal;

    always_comb begin
        st_d      = st_q;
        fall_both = below_switch && below_bat;
        reseal    = attach_evt && !above_trip;

        if (reseal) begin
            st_d.mode = SRC_SEALED;
        end else begin
            unique case (st_q.mode)
                SRC_SEALED: if (above_trip) st_d.mode = SRC_MAIN;
                SRC_MAIN:   if (fall_both)  st_d.mode = SRC_BACKUP;
                SRC_BACKUP: if (!fall_both) st_d.mode = SRC_MAIN;
                default:                    st_d.mode = SRC_SEALED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: SRC_SEALED};
        else        st_q <= st_d;
    end

    assign bat_sel = (st_q.mode == SRC_BACKUP);

endmodule

// File: rtl/reset_hold_timer.sv
module reset_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 6554
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_trip,
    output logic rst_out_n
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!above_trip) begin
            h_d.cnt  = '0;
            h_d.done = 1'b0;
        end else if (!h_q.done) begin
            if (h_q.cnt == LAST) h_d.done = 1'b1;
            else                 h_d.cnt  = h_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // Drop is immediate; release waits for the hold count.
    assign rst_out_n = h_q.done && above_trip;

endmodule

// File: rtl/bkup_switch_supervisor.sv
module bkup_switch_supervisor #(
    parameter int unsigned HOLD_CYCLES = 6554
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_trip,
    input  logic vcc_below_switch,
    input  logic vcc_below_bat,
    input  logic battery_attach_event,
    output logic bat_sel,
    output logic rst_out_n
);

    supply_select_fsm u_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .above_trip   (vcc_above_trip),
        .below_switch (vcc_below_switch),
        .below_bat    (vcc_below_bat),
        .attach_evt   (battery_attach_event),
        .bat_sel      (bat_sel)
    );

    reset_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_trip (vcc_above_trip),
        .rst_out_n  (rst_out_n)
    );

endmodule

// File: rtl/bkup_switch_supervisor_chk.sv
module bkup_switch_supervisor_chk #(
    parameter int unsigned HOLD_CYCLES = 6554
) (
    input logic clk,
    input logic rst_n,
    input logic vcc_above_trip,
    input logic vcc_below_switch,
    input logic vcc_below_bat,
    input logic battery_attach_event,
    input logic bat_sel,
    input logic rst_out_n
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] up_cnt_q;
    logic             armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_cnt_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (!vcc_above_trip)    up_cnt_q <= '0;
            else if (up_cnt_q != FULL) up_cnt_q <= up_cnt_q + 1'b1;

            if (battery_attach_event && !vcc_above_trip) armed_q <= 1'b0;
            else if (vcc_above_trip)                      armed_q <= 1'b1;
        end
    end

    // R1
    sel_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> $past(vcc_below_switch && vcc_below_bat));

    // R2
    sealed_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> armed_q);

    // R5
    reseal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (battery_attach_event && !vcc_above_trip) |=> !bat_sel);

    // R7
    rst_drop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_above_trip |-> !rst_out_n);

    // R8
    rst_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out_n |-> (up_cnt_q == FULL));

    // R9
    rst_not_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_above_trip && up_cnt_q == FULL) |-> rst_out_n);

    // R10
    always_comb begin
        if (!rst_n) begin
            in_reset_low_chk: assert (!rst_out_n);
        end
    end

endmodule

bind bkup_switch_supervisor bkup_switch_supervisor_chk #(
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk                  (clk),
    .rst_n                (rst_n),
    .vcc_above_trip       (vcc_above_trip),
    .vcc_below_switch     (vcc_below_switch),
    .vcc_below_bat        (vcc_below_bat),
    .battery_attach_event (battery_attach_event),
    .bat_sel              (bat_sel),
    .rst_out_n            (rst_out_n)
);

// File: tb/bkup_switch_supervisor_bench.sv
module bkup_switch_supervisor_bench;

    localparam int unsigned HOLD = 8;
    localparam int          NVEC = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0;
    logic bsw = 1'b0;
    logic bbat = 1'b0;
    logic attach = 1'b0;
    logic bat_sel;
    logic rst_out_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    bkup_switch_supervisor #(.HOLD_CYCLES(HOLD)) u_bkup_switch_supervisor (
        .clk                  (clk),
        .rst_n                (rst_n),
        .vcc_above_trip       (above),
        .vcc_below_switch     (bsw),
        .vcc_below_bat        (bbat),
        .battery_attach_event (attach),
        .bat_sel              (bat_sel),
        .rst_out_n            (rst_out_n)
    );

    // {req[3:0], above, below_switch, below_bat, attach, expected bat_sel}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd2, 5'b0_1_1_0_0},   // R2 sealed, both low flags
        {4'd2, 5'b0_1_1_1_0},   // R2 attach while sealed
        {4'd2, 5'b0_0_0_0_0},   // R2
        {4'd3, 5'b1_0_0_0_0},   // R3 arm
        {4'd3, 5'b0_0_0_0_0},   // R3 between trip and switch
        {4'd1, 5'b0_1_0_0_0},   // R1 switch flag alone
        {4'd1, 5'b0_0_1_0_0},   // R1 battery flag alone
        {4'd3, 5'b0_1_1_0_1},   // R3 enter backup
        {4'd3, 5'b0_1_1_0_1},   // R3 hold backup
        {4'd4, 5'b0_0_1_0_0},   // R4 switch flag clears
        {4'd4, 5'b0_1_1_0_1},   // R4 still unsealed
        {4'd4, 5'b0_1_0_0_0},   // R4 battery flag clears
        {4'd4, 5'b0_1_1_0_1},   // R4
        {4'd5, 5'b0_1_1_1_0},   // R5 attach with supply down
        {4'd5, 5'b0_1_1_0_0},   // R5 stays sealed
        {4'd5, 5'b0_0_0_0_0},   // R5
        {4'd6, 5'b1_0_0_0_0},   // R6 rearm
        {4'd6, 5'b1_0_0_1_0},   // R6 attach with supply up
        {4'd6, 5'b0_1_1_0_1}    // R6 still armed
    };

    task automatic check(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        above = 1'b0; bsw = 1'b0; bbat = 1'b0; attach = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R10: outputs low in reset even with supply up
        above = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 rst_out_n in reset", rst_out_n, 1'b0);
        check("R10 bat_sel in reset", bat_sel, 1'b0);
        above = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Selection table, each vector checked one clock later
        for (int i = 0; i < NVEC; i++) begin
            {above, bsw, bbat, attach} = VEC[i][4:1];
            @(negedge clk);
            attach = 1'b0;
            check($sformatf("R%0d vec %0d", VEC[i][8:5], i), bat_sel, VEC[i][0]);
        end

        // R10: asynchronous reset from backup
        #3;
        rst_n = 1'b0;
        #1;
        check("R10 async bat_sel", bat_sel, 1'b0);
        check("R10 async rst_out_n", rst_out_n, 1'b0);
        do_reset();

        // R8: exact release edge
        above = 1'b1;
        for (int k = 1; k <= HOLD + 1; k++) begin
            @(negedge clk);
            check($sformatf("R8 edge %0d", k), rst_out_n, (k >= HOLD));
        end

        // R7: immediate drop
        #2;
        above = 1'b0;
        #1;
        check("R7 immediate drop", rst_out_n, 1'b0);
        @(negedge clk);
        check("R7 stays low", rst_out_n, 1'b0);

        // R9: dip one edge before release restarts the count
        above = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        check("R9 before dip", rst_out_n, 1'b0);
        above = 1'b0;
        @(negedge clk);
        above = 1'b1;
        for (int k = 1; k <= HOLD; k++) begin
            @(negedge clk);
            check($sformatf("R9 restart edge %0d", k), rst_out_n, (k >= HOLD));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule